// File: doc/BRIEF.md
# Staggered CAS-before-RAS DRAM Refresh Sequencer

This block keeps a bank-organised DRAM array alive without any help from software. The array is four double-sided memory modules, which gives eight independently strobed RAS/CAS banks. A free-running interval timer, sized at build time from the clock rate, the retention window (32 ms) and the number of rows per bank, raises a refresh request at evenly spaced points. Each request refreshes exactly one bank with a CAS-before-RAS cycle. Only one bank draws refresh current at a time, and the row address comes from the DRAM's internal counter, so no address is needed.

The block shares the memory strobes with the processor's memory controller through a request/grant pair. When a request is pending, the block raises `refresh_req`. The controller finishes any cycle already in flight and then answers with `mem_grant`. From the next clock the sequencer owns the strobes and drives `refresh_busy` to hold the processor off. It raises `addr_tristate` so the address drivers stay released. The bank pointer then steps to the next bank. The block starts on the first clock after reset, has no registers that software can see, and flags a request that could not be served before the next one fell due.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `ras_n` and `cas_n` bit is high, and `refresh_busy`, `addr_tristate`, `refresh_req` and `missed_deadline` are low.
- R2: With `mem_grant` held high, consecutive refresh cycles start exactly TICK_CYC = WINDOW_CYC / (ROWS x BANKS) clocks apart, so every bank receives ROWS refreshes per window.
- R3: At most one bank has any strobe low at a time. Bit b of `cas_n`/`ras_n` belongs to bank b. Banks are served in the order 0, 1, ..., BANKS-1, 0, ..., starting from bank 0 after reset, and the pointer advances only when a refresh cycle completes.
- R4: A refresh cycle drives the selected bank's CAS low alone for T_CSR clocks. It then drives RAS low together with CAS for T_RAS clocks and releases both in the same clock. RAS is never low on a bank whose CAS is high.
- R5: No strobe moves while `mem_grant` is low. `refresh_req` stays high until it is granted. The selected CAS goes low on the clock after the one in which `refresh_req` and `mem_grant` are both high.
- R6: `refresh_busy` and `addr_tristate` are high from the first CAS clock through T_RP precharge clocks after the strobes release.
- R7: After the precharge clocks, `refresh_busy`, `addr_tristate` and `refresh_req` are low until the next timer expiry.
- R8: If the timer expires while the previous request has not yet finished, `missed_deadline` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_grant | input | 1 | Memory controller yields the strobes (no cycle in flight) |
| refresh_req | output | 1 | A refresh is pending and waits for a grant |
| refresh_busy | output | 1 | Refresh owns the DRAM; processor cycles held off |
| addr_tristate | output | 1 | Address drivers released during refresh |
| ras_n | output | BANKS | Active-low row strobe per bank |
| cas_n | output | BANKS | Active-low column strobe per bank |
| missed_deadline | output | 1 | Sticky flag: a request fell due before the previous one finished |

## Verification
The embedded assertions watch, on every clock, that at most one bank is strobed and that RAS never falls without CAS on the same bank. They also check that a sequence begins only after a granted request, that the bank pointer steps by one per completed cycle, that the timer never fires on two adjacent clocks, and that the missed flag never clears by itself. Exact phase lengths, the spacing of successive refreshes, the bank rotation order, and behaviour under grants withheld for various lengths of time or past a whole interval can only be shown by the bench's scenarios. The bench measures these against timing computed from the parameters.

// File: rtl/refresh_pkg.sv
// Shared types for the staggered CBR refresh sequencer.
// Assumes: included first in compile order.
package refresh_pkg;

    // Phases of one CAS-before-RAS refresh cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // strobes released, bus belongs to the CPU
        PH_CAS  = 2'd1,   // column strobe alone (CAS-to-RAS setup)
        PH_RAS  = 2'd2,   // row and column strobes both active
        PH_PRE  = 2'd3    // strobes released, precharge before handing back
    } cbr_phase_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
// Interval timer: emits a one-clock pulse every TICK_CYC clocks, free-running
// from reset. Assumes TICK_CYC >= 1; the first pulse falls TICK_CYC-1 clocks
// after reset release.
module rfsh_interval_timer #(
    parameter int TICK_CYC = 97
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] count_q;

    // Count clocks modulo TICK_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (count_q == LAST)
            count_q <= '0;
        else
            count_q <= count_q + 1'b1;
    end

    // Pulse on the last count of each interval.
    assign tick = (count_q == LAST);

    generate
        if (TICK_CYC > 1) begin : g_spacing_chk
            // R2: pulses are spread out, never back to back.
            assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("timer fired on adjacent clocks");
        end
    endgenerate

endmodule

// File: rtl/rfsh_arbiter.sv
// Request tracker and handshake: records a timer expiry as a pending request,
// asks the memory controller for the strobes, starts the CBR engine on grant,
// and latches a sticky flag when a new expiry finds the previous request
// unfinished. Assumes the engine pulses seq_done on its last busy clock.
module rfsh_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mem_grant,
    input  logic seq_idle,
    input  logic seq_done,
    output logic refresh_req,
    output logic seq_start,
    output logic missed_deadline
);

    logic pending_q;
    logic missed_q;

    // Hold a request from timer expiry until its cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (tick)
            pending_q <= 1'b1;
        else if (seq_done)
            pending_q <= 1'b0;
    end

    // Latch a missed deadline until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            missed_q <= 1'b0;
        else if (tick && pending_q && !seq_done)
            missed_q <= 1'b1;
    end

    // Ask for the bus only while the engine is free.
    assign refresh_req     = pending_q && seq_idle;
    assign seq_start       = refresh_req && mem_grant;
    assign missed_deadline = missed_q;

    // R5: the engine leaves idle only after a granted request.
    assert_start_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_idle) |-> $past(mem_grant && refresh_req))
        else $error("refresh began without a grant");

    // R8: the missed flag never clears while out of reset.
    assert_missed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        missed_deadline |=> missed_deadline)
        else $error("missed flag cleared");

endmodule

// File: rtl/rfsh_cbr_engine.sv
// CBR engine: on seq_start, drives CAS on the selected bank for T_CSR clocks,
// adds RAS for T_RAS clocks, releases both, waits T_RP clocks, then steps the
// bank pointer. Strobes decode from registered state. Assumes all delays >= 1
// and that seq_start arrives only while idle.
module rfsh_cbr_engine
    import refresh_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int T_CSR = 2,
    parameter int T_RAS = 5,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_start,
    output logic             seq_idle,
    output logic             seq_done,
    output logic             busy,
    output logic [BANKS-1:0] ras_n,
    output logic [BANKS-1:0] cas_n
);

    localparam int BW   = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                          : ((T_RAS > T_RP) ? T_RAS : T_RP);
    localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [BW-1:0] LAST_BANK = BW'(BANKS - 1);

    cbr_phase_t    phase_q;
    logic [TW-1:0] wait_q;
    logic [BW-1:0] bank_q;

    // Step through the CBR phases, each timed by a down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wait_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (seq_start) begin
                    phase_q <= PH_CAS;
                    wait_q  <= TW'(T_CSR - 1);
                end
                PH_CAS: if (wait_q == '0) begin
                    phase_q <= PH_RAS;
                    wait_q  <= TW'(T_RAS - 1);
                end else begin
                    wait_q <= wait_q - 1'b1;
                end
                PH_RAS: if (wait_q == '0) begin
                    phase_q <= PH_PRE;
                    wait_q  <= TW'(T_RP - 1);
                end else begin
                    wait_q <= wait_q - 1'b1;
                end
                default: if (wait_q == '0) begin
                    phase_q <= PH_IDLE;
                end else begin
                    wait_q <= wait_q - 1'b1;
                end
            endcase
        end
    end

    // Rotate to the next bank once a cycle has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (seq_done)
            bank_q <= (bank_q == LAST_BANK) ? '0 : bank_q + 1'b1;
    end

    assign seq_idle = (phase_q == PH_IDLE);
    assign busy     = !seq_idle;
    assign seq_done = (phase_q == PH_PRE) && (wait_q == '0);

    // Decode one strobe pair per bank.
    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic sel;
            assign sel      = (bank_q == BW'(b));
            assign cas_n[b] = !(sel && (phase_q == PH_CAS || phase_q == PH_RAS));
            assign ras_n[b] = !(sel && (phase_q == PH_RAS));
        end
    endgenerate

    // R3: no more than one bank strobed at any time.
    assert_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cas_n))
        else $error("several banks strobed");

    // R4: row strobe only on a bank that already has its column strobe.
    assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ras_n) & cas_n) == '0)
        else $error("RAS without CAS");

    // R3: pointer advances by exactly one bank per completed cycle.
    assert_bank_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bank_q == (($past(bank_q) == LAST_BANK) ? '0 : $past(bank_q) + 1'b1)))
        else $error("bank pointer skipped");

    // R6: any active strobe lies inside a busy window.
    assert_strobe_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~cas_n)) |-> busy)
        else $error("strobe outside busy window");

endmodule

// File: rtl/dram_refresh_seq.sv
// Top of the staggered CBR refresh sequencer for BANKS RAS/CAS banks.
// Derives the request spacing from the retention window so that every bank
// gets ROWS refreshes per window. Assumes the memory controller raises
// mem_grant only while no processor cycle is in flight and starts none while
// refresh_req or refresh_busy is high, and that one refresh cycle
// (T_CSR+T_RAS+T_RP clocks) is shorter than the spacing.
module dram_refresh_seq #(
    parameter int BANKS      = 8,
    parameter int ROWS       = 2048,
    parameter int WINDOW_CYC = 1_600_000,
    parameter int T_CSR      = 2,
    parameter int T_RAS      = 5,
    parameter int T_RP       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_grant,
    output logic             refresh_req,
    output logic             refresh_busy,
    output logic             addr_tristate,
    output logic [BANKS-1:0] ras_n,
    output logic [BANKS-1:0] cas_n,
    output logic             missed_deadline
);

    localparam int TICK_CYC = WINDOW_CYC / (ROWS * BANKS);

    logic tick;
    logic seq_start;
    logic seq_idle;
    logic seq_done;
    logic busy;

    rfsh_interval_timer #(
        .TICK_CYC (TICK_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfsh_arbiter u_arb (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .mem_grant       (mem_grant),
        .seq_idle        (seq_idle),
        .seq_done        (seq_done),
        .refresh_req     (refresh_req),
        .seq_start       (seq_start),
        .missed_deadline (missed_deadline)
    );

    rfsh_cbr_engine #(
        .BANKS (BANKS),
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_start (seq_start),
        .seq_idle  (seq_idle),
        .seq_done  (seq_done),
        .busy      (busy),
        .ras_n     (ras_n),
        .cas_n     (cas_n)
    );

    // Busy holds off the CPU and releases the address bus.
    assign refresh_busy  = busy;
    assign addr_tristate = busy;

endmodule

// File: tb/tb_dram_refresh_seq.sv
// Bench: small configuration (8 banks, 40-clock spacing). It sweeps the full
// bank rotation twice, sweeps the grant delay and forces a missed deadline.
module tb_dram_refresh_seq;

    localparam int NB     = 8;
    localparam int ROWS   = 4;
    localparam int WIN    = 1280;
    localparam int TICK   = WIN / (ROWS * NB);
    localparam int TCSR   = 2;
    localparam int TRAS   = 4;
    localparam int TRP    = 3;
    localparam logic [NB-1:0] ALL1 = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_grant = 1'b0;
    logic          refresh_req, refresh_busy, addr_tristate, missed_deadline;
    logic [NB-1:0] ras_n, cas_n;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    dram_refresh_seq #(
        .BANKS (NB), .ROWS (ROWS), .WINDOW_CYC (WIN),
        .T_CSR (TCSR), .T_RAS (TRAS), .T_RP (TRP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .mem_grant (mem_grant),
        .refresh_req (refresh_req), .refresh_busy (refresh_busy),
        .addr_tristate (addr_tristate), .ras_n (ras_n), .cas_n (cas_n),
        .missed_deadline (missed_deadline)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [NB-1:0] sel(input int b);
        return ~(NB'(1) << b);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ras_n == ALL1 && cas_n == ALL1, "R1 strobes", {ras_n, cas_n}, {ALL1, ALL1});
        chk({refresh_busy, addr_tristate, refresh_req, missed_deadline} == 4'b0, "R1 flags",
            {refresh_busy, addr_tristate, refresh_req, missed_deadline}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cas_n == ALL1 && !refresh_busy && !missed_deadline, "R1 after release",
            {cas_n, refresh_busy, missed_deadline}, {ALL1, 2'b0});
    endtask

    // Poll negedges until some CAS is low; returns its cycle number.
    task automatic wait_cas(output int t);
        int n = 0;
        while (cas_n == ALL1 && n < 4 * TICK) begin
            @(negedge clk);
            n++;
        end
        chk(cas_n != ALL1, "R2 refresh appears", cas_n, 0);
        t = cyc;
    endtask

    task automatic wait_req();
        int n = 0;
        while (!refresh_req && n < 4 * TICK) begin
            @(negedge clk);
            n++;
        end
        chk(refresh_req, "R5 request raised", refresh_req, 1);
    endtask

    // Called at the first negedge where the bank's CAS is low.
    task automatic run_seq(input int b);
        for (int i = 0; i < TCSR; i++) begin
            if (i > 0) @(negedge clk);
            chk(cas_n == sel(b) && ras_n == ALL1 && refresh_busy && addr_tristate,
                "R4 CAS-only phase", {ras_n, cas_n}, {ALL1, sel(b)});
        end
        for (int i = 0; i < TRAS; i++) begin
            @(negedge clk);
            chk(cas_n == sel(b) && ras_n == sel(b) && refresh_busy && addr_tristate,
                "R4 RAS+CAS phase", {ras_n, cas_n}, {sel(b), sel(b)});
        end
        for (int i = 0; i < TRP; i++) begin
            @(negedge clk);
            chk(cas_n == ALL1 && ras_n == ALL1 && refresh_busy && addr_tristate,
                "R6 precharge busy", {refresh_busy, addr_tristate, cas_n}, {2'b11, ALL1});
        end
        @(negedge clk);
        chk(!refresh_busy && !addr_tristate && !refresh_req, "R7 released",
            {refresh_busy, addr_tristate, refresh_req}, 0);
    endtask

    initial begin
        #(20ns * 20000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t, prev;
        prev = 0;

        // Phase 1: grant always available, two full rotations (R2, R3).
        mem_grant = 1'b0;
        do_reset();
        mem_grant = 1'b1;
        for (int k = 0; k < 2 * NB; k++) begin
            wait_cas(t);
            chk(cas_n == sel(k % NB), "R3 bank order", cas_n, sel(k % NB));
            if (k > 0) chk(t - prev == TICK, "R2 spacing", t - prev, TICK);
            prev = t;
            run_seq(k % NB);
        end
        chk(!missed_deadline, "R8 no miss when served", missed_deadline, 0);

        // Phase 2: grant withheld for d clocks after each request (R5).
        mem_grant = 1'b0;
        do_reset();
        for (int d = 0; d < 10; d++) begin
            wait_req();
            for (int j = 0; j < d; j++) begin
                @(negedge clk);
                chk(cas_n == ALL1 && ras_n == ALL1 && !refresh_busy && refresh_req,
                    "R5 wait for grant", {refresh_busy, refresh_req, cas_n}, {2'b01, ALL1});
            end
            mem_grant = 1'b1;
            @(negedge clk);
            chk(cas_n == sel(d % NB), "R5 start after grant", cas_n, sel(d % NB));
            run_seq(d % NB);
            mem_grant = 1'b0;
        end
        chk(!missed_deadline, "R8 no miss within window", missed_deadline, 0);

        // Phase 3: grant withheld past a whole interval (R8).
        repeat (2 * TICK + 2) @(negedge clk);
        chk(missed_deadline, "R8 flag raised", missed_deadline, 1);
        chk(cas_n == ALL1 && refresh_req, "R5 still waiting", {refresh_req, cas_n}, {1'b1, ALL1});
        mem_grant = 1'b1;
        @(negedge clk);
        chk(cas_n == sel(10 % NB), "R3 bank after miss", cas_n, sel(10 % NB));
        run_seq(10 % NB);
        chk(missed_deadline, "R8 flag sticky", missed_deadline, 1);
        mem_grant = 1'b0;
        do_reset();
        chk(!missed_deadline, "R8 cleared by reset", missed_deadline, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule